// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer with Unconditional Folding

This block sits beside the instruction memory in the fetch stage. In the cycle the fetch address is presented, it looks the address up in a small direct-mapped table of branches that were taken before. On a hit it names the predicted next fetch address at once, so the next fetch goes to the target without waiting for decode. Entries marked unconditional also carry a copy of the instruction found at the target. On a hit to such an entry the block puts that stored instruction in place of the one returned by memory and moves fetch past the target. The branch instruction then disappears from the stream at no cost.

Later pipeline stages report each resolved branch: its address, whether fetch hit on it, the target fetch predicted, the real direction and target, an unconditional flag and the target instruction. The block classifies the outcome and reports a penalty of 0 or 2 cycles in the same cycle. For every outcome that costs cycles it runs a fixed recovery. In the first cycle the table is written and fetch is held. In the second cycle fetch is redirected to the correct address. Only branches that were taken stay in the table. An entry whose branch falls through is removed.

Top module: `btb_fold_top`

## Requirements
- R1: After reset every entry is invalid. `hit_o`, `fold_o` and `stall_o` are 0, `next_pc_o` equals the fetch address plus 4, and `instr_o` equals `imem_instr_i`.
- R2: The entry index is fetch address bits [5:2] and the tag is bits [31:6]. A lookup hits in the same cycle when `fetch_valid_i` is 1 and the indexed entry is valid with an equal tag. On a hit to a conditional entry, `next_pc_o` is the stored target. An entry at the same index with a different tag gives a miss.
- R3: A resolved branch that missed and was not taken reports penalty 0. It causes no stall and no allocation.
- R4: A resolved branch that missed and was taken reports penalty 2. It allocates an entry holding its target, unconditional flag and target instruction.
- R5: A resolved branch that hit and was taken to the predicted target reports penalty 0. It causes no stall and leaves the entry unchanged.
- R6: A resolved branch that hit and was taken to a different target reports penalty 2. Its entry is rewritten with the new target.
- R7: A resolved branch that hit but was not taken reports penalty 2. Its entry is invalidated.
- R8: Each penalty-2 resolution holds `stall_o` high for exactly the two cycles after the resolve cycle. The table write takes effect at the end of the first of these cycles. In the second cycle `redirect_o` is 1 and `redirect_pc_o` is the real target (taken) or the branch address plus 4 (not taken).
- R9: On a hit to an unconditional entry, `fold_o` is 1, `instr_o` is the stored target instruction and `next_pc_o` is the stored target plus 4. On a conditional hit, `instr_o` passes `imem_instr_i` through.
- R10: During the write cycle, a lookup whose index equals the index being written reports a miss.
- R11: A resolve presented while `stall_o` is high is ignored. No penalty is reported and the table is left unchanged.
- R12: `pen_valid_o` is 1 in the same cycle as each accepted resolve, and `pen_cycles_o` is 0 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Fetch address is valid this cycle |
| fetch_pc_i | input | 32 | Current fetch address |
| imem_instr_i | input | 32 | Instruction returned by instruction memory |
| hit_o | output | 1 | Lookup hit |
| fold_o | output | 1 | Unconditional branch folded this cycle |
| next_pc_o | output | 32 | Predicted next fetch address |
| instr_o | output | 32 | Instruction passed to decode |
| rslv_valid_i | input | 1 | A branch resolution is presented |
| rslv_pc_i | input | 32 | Address of the resolved branch |
| rslv_hit_i | input | 1 | Fetch hit on this branch |
| rslv_pred_tgt_i | input | 32 | Target fetch predicted for it |
| rslv_taken_i | input | 1 | Real direction |
| rslv_target_i | input | 32 | Real target |
| rslv_uncond_i | input | 1 | Branch is unconditional |
| rslv_tinstr_i | input | 32 | Instruction at the real target |
| pen_valid_o | output | 1 | Penalty report valid |
| pen_cycles_o | output | 2 | Penalty in cycles, 0 or 2 |
| stall_o | output | 1 | Fetch held for recovery |
| redirect_o | output | 1 | Restart fetch this cycle |
| redirect_pc_o | output | 32 | Restart address |

## Verification
Properties checked on every cycle cover the recovery timing: a rising stall lasts exactly two cycles, and a penalty-2 report is followed by a write cycle and then a redirect. They also check that each table write leaves the written entry valid or invalid as asked, that a miss predicts the sequential address, and that no hit is reported on an index under write. The penalty code is also checked to be 0 or 2. Only the directed scenarios can show the contents of the table. These include allocation that depends on the outcome, the target rewrite, removal of entries that fall through, the stored instruction and address used when folding, aliasing between tags, and resolves dropped during a stall.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    REC_IDLE    = 2'd0,
    REC_UPDATE  = 2'd1,
    REC_RESTART = 2'd2
  } rec_state_e;

  localparam logic [1:0] PEN_NONE = 2'd0;
  localparam logic [1:0] PEN_FULL = 2'd2;

  function automatic logic is_mispredict(input logic hit, input logic taken,
                                         input logic tgt_match);
    if (hit) return !taken || !tgt_match;
    else     return taken;
  endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 26
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic               rd_valid_o,
  output logic [TAG_W-1:0]   rd_tag_o,
  output logic [PC_W-1:0]    rd_tgt_o,
  output logic               rd_uncond_o,
  output logic [INSTR_W-1:0] rd_instr_o,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_valid_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [PC_W-1:0]    wr_tgt_i,
  input  logic               wr_uncond_i,
  input  logic [INSTR_W-1:0] wr_instr_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]   valid_q;
  logic [TAG_W-1:0]   tag_q    [DEPTH];
  logic [PC_W-1:0]    tgt_q    [DEPTH];
  logic [DEPTH-1:0]   uncond_q;
  logic [INSTR_W-1:0] instr_q  [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  valid_q[e] <= 1'b0;
      else if (sel) valid_q[e] <= wr_valid_i;
    end

    always_ff @(posedge clk_i) begin
      if (sel && wr_valid_i) begin
        tag_q[e]    <= wr_tag_i;
        tgt_q[e]    <= wr_tgt_i;
        uncond_q[e] <= wr_uncond_i;
        instr_q[e]  <= wr_instr_i;
      end
    end
  end

  assign rd_valid_o  = valid_q[rd_idx_i];
  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_tgt_o    = tgt_q[rd_idx_i];
  assign rd_uncond_o = uncond_q[rd_idx_i];
  assign rd_instr_o  = instr_q[rd_idx_i];

  // The entry written last cycle now carries the requested validity
  assert_write_lands_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (valid_q[$past(wr_idx_i)] == $past(wr_valid_i)));

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 26
) (
  input  logic               fetch_valid_i,
  input  logic [PC_W-1:0]    fetch_pc_i,
  input  logic [INSTR_W-1:0] imem_instr_i,
  output logic [IDX_W-1:0]   rd_idx_o,
  input  logic               rd_valid_i,
  input  logic [TAG_W-1:0]   rd_tag_i,
  input  logic [PC_W-1:0]    rd_tgt_i,
  input  logic               rd_uncond_i,
  input  logic [INSTR_W-1:0] rd_instr_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  output logic               hit_o,
  output logic               fold_o,
  output logic [PC_W-1:0]    next_pc_o,
  output logic [INSTR_W-1:0] instr_o
);
  localparam int OFS_W = 2;

  logic [TAG_W-1:0] pc_tag;
  logic             tag_eq;
  logic             wr_clash;

  assign rd_idx_o = fetch_pc_i[OFS_W +: IDX_W];
  assign pc_tag   = fetch_pc_i[OFS_W+IDX_W +: TAG_W];
  assign tag_eq   = (rd_tag_i == pc_tag);
  assign wr_clash = wr_en_i && (wr_idx_i == rd_idx_o);

  always_comb begin
    hit_o     = fetch_valid_i && rd_valid_i && tag_eq && !wr_clash;
    fold_o    = hit_o && rd_uncond_i;
    instr_o   = imem_instr_i;
    next_pc_o = fetch_pc_i + PC_W'(4);
    if (fold_o) begin
      instr_o   = rd_instr_i;
      next_pc_o = rd_tgt_i + PC_W'(4);
    end else if (hit_o) begin
      next_pc_o = rd_tgt_i;
    end
  end

endmodule

// File: rtl/btb_recover.sv
module btb_recover
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 26
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rslv_valid_i,
  input  logic [PC_W-1:0]    rslv_pc_i,
  input  logic               rslv_hit_i,
  input  logic [PC_W-1:0]    rslv_pred_tgt_i,
  input  logic               rslv_taken_i,
  input  logic [PC_W-1:0]    rslv_target_i,
  input  logic               rslv_uncond_i,
  input  logic [INSTR_W-1:0] rslv_tinstr_i,
  output logic               pen_valid_o,
  output logic [1:0]         pen_cycles_o,
  output logic               stall_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic               wr_en_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic               wr_valid_o,
  output logic [TAG_W-1:0]   wr_tag_o,
  output logic [PC_W-1:0]    wr_tgt_o,
  output logic               wr_uncond_o,
  output logic [INSTR_W-1:0] wr_instr_o
);
  localparam int OFS_W = 2;

  rec_state_e state_q, state_d;
  logic       accept, mispred, load;

  logic [IDX_W-1:0]   idx_q;
  logic               valid_q;
  logic [TAG_W-1:0]   tag_q;
  logic [PC_W-1:0]    tgt_q;
  logic               uncond_q;
  logic [INSTR_W-1:0] instr_q;
  logic [PC_W-1:0]    redir_q;

  assign accept  = rslv_valid_i && (state_q == REC_IDLE);
  assign mispred = is_mispredict(rslv_hit_i, rslv_taken_i,
                                 rslv_pred_tgt_i == rslv_target_i);
  assign load    = accept && mispred;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      REC_IDLE:    if (load) state_d = REC_UPDATE;
      REC_UPDATE:  state_d = REC_RESTART;
      REC_RESTART: state_d = REC_IDLE;
      default:     state_d = REC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= REC_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i) begin
    if (load) begin
      idx_q    <= rslv_pc_i[OFS_W +: IDX_W];
      tag_q    <= rslv_pc_i[OFS_W+IDX_W +: TAG_W];
      valid_q  <= rslv_taken_i;
      tgt_q    <= rslv_target_i;
      uncond_q <= rslv_uncond_i;
      instr_q  <= rslv_tinstr_i;
      redir_q  <= rslv_taken_i ? rslv_target_i : rslv_pc_i + PC_W'(4);
    end
  end

  assign pen_valid_o   = accept;
  assign pen_cycles_o  = mispred ? PEN_FULL : PEN_NONE;
  assign stall_o       = (state_q != REC_IDLE);
  assign redirect_o    = (state_q == REC_RESTART);
  assign redirect_pc_o = redir_q;
  assign wr_en_o       = (state_q == REC_UPDATE);
  assign wr_idx_o      = idx_q;
  assign wr_valid_o    = valid_q;
  assign wr_tag_o      = tag_q;
  assign wr_tgt_o      = tgt_q;
  assign wr_uncond_o   = uncond_q;
  assign wr_instr_o    = instr_q;

  assert_stall_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |=> stall_o);
  assert_stall_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && $past(stall_o)) |=> !stall_o);
  assert_pen_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pen_valid_o && pen_cycles_o == PEN_FULL) |=> (wr_en_o && !redirect_o) ##1 redirect_o);
  assert_pen_code_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pen_valid_o |-> (pen_cycles_o == PEN_NONE || pen_cycles_o == PEN_FULL));

endmodule

// File: rtl/btb_fold_top.sv
module btb_fold_top #(
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_valid_i,
  input  logic [PC_W-1:0]    fetch_pc_i,
  input  logic [INSTR_W-1:0] imem_instr_i,
  output logic               hit_o,
  output logic               fold_o,
  output logic [PC_W-1:0]    next_pc_o,
  output logic [INSTR_W-1:0] instr_o,
  input  logic               rslv_valid_i,
  input  logic [PC_W-1:0]    rslv_pc_i,
  input  logic               rslv_hit_i,
  input  logic [PC_W-1:0]    rslv_pred_tgt_i,
  input  logic               rslv_taken_i,
  input  logic [PC_W-1:0]    rslv_target_i,
  input  logic               rslv_uncond_i,
  input  logic [INSTR_W-1:0] rslv_tinstr_i,
  output logic               pen_valid_o,
  output logic [1:0]         pen_cycles_o,
  output logic               stall_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o
);
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [IDX_W-1:0]   rd_idx;
  logic               rd_valid, rd_uncond;
  logic [TAG_W-1:0]   rd_tag;
  logic [PC_W-1:0]    rd_tgt;
  logic [INSTR_W-1:0] rd_instr;
  logic               wr_en, wr_valid, wr_uncond;
  logic [IDX_W-1:0]   wr_idx;
  logic [TAG_W-1:0]   wr_tag;
  logic [PC_W-1:0]    wr_tgt;
  logic [INSTR_W-1:0] wr_instr;

  btb_store #(.PC_W(PC_W), .INSTR_W(INSTR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) store_i (
    .clk_i, .rst_ni,
    .rd_idx_i(rd_idx), .rd_valid_o(rd_valid), .rd_tag_o(rd_tag), .rd_tgt_o(rd_tgt),
    .rd_uncond_o(rd_uncond), .rd_instr_o(rd_instr),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid), .wr_tag_i(wr_tag),
    .wr_tgt_i(wr_tgt), .wr_uncond_i(wr_uncond), .wr_instr_i(wr_instr)
  );

  btb_lookup #(.PC_W(PC_W), .INSTR_W(INSTR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) lookup_i (
    .fetch_valid_i, .fetch_pc_i, .imem_instr_i,
    .rd_idx_o(rd_idx), .rd_valid_i(rd_valid), .rd_tag_i(rd_tag), .rd_tgt_i(rd_tgt),
    .rd_uncond_i(rd_uncond), .rd_instr_i(rd_instr),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .hit_o, .fold_o, .next_pc_o, .instr_o
  );

  btb_recover #(.PC_W(PC_W), .INSTR_W(INSTR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) recover_i (
    .clk_i, .rst_ni,
    .rslv_valid_i, .rslv_pc_i, .rslv_hit_i, .rslv_pred_tgt_i, .rslv_taken_i,
    .rslv_target_i, .rslv_uncond_i, .rslv_tinstr_i,
    .pen_valid_o, .pen_cycles_o, .stall_o, .redirect_o, .redirect_pc_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_valid_o(wr_valid), .wr_tag_o(wr_tag),
    .wr_tgt_o(wr_tgt), .wr_uncond_o(wr_uncond), .wr_instr_o(wr_instr)
  );

  assert_no_hit_on_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_idx == rd_idx) |-> !hit_o);
  assert_write_in_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (stall_o && !redirect_o));
  assert_miss_seq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (next_pc_o == fetch_pc_i + PC_W'(4) && instr_o == imem_instr_i));

endmodule

// File: tb/btb_fold_top_tb.sv
module btb_fold_top_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic        fv, hit, fold, rv, rhit, rtaken, runc, pen_v, stall, redir;
  logic [31:0] fpc, imem, npc, instr, rpc, rptgt, rtgt, rtinstr, redir_pc;
  logic [1:0]  pen;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  btb_fold_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fv), .fetch_pc_i(fpc), .imem_instr_i(imem),
    .hit_o(hit), .fold_o(fold), .next_pc_o(npc), .instr_o(instr),
    .rslv_valid_i(rv), .rslv_pc_i(rpc), .rslv_hit_i(rhit), .rslv_pred_tgt_i(rptgt),
    .rslv_taken_i(rtaken), .rslv_target_i(rtgt), .rslv_uncond_i(runc),
    .rslv_tinstr_i(rtinstr), .pen_valid_o(pen_v), .pen_cycles_o(pen),
    .stall_o(stall), .redirect_o(redir), .redirect_pc_o(redir_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Look up pc in the current cycle (inputs driven after a falling edge)
  task automatic look(input logic [31:0] pc, input string req, input logic e_hit,
                      input logic [31:0] e_npc);
    @(negedge clk);
    fv = 1'b1; fpc = pc; imem = 32'hABCD0000 ^ pc;
    #1;
    chk(req, {31'd0, hit}, {31'd0, e_hit});
    chk(req, npc, e_npc);
  endtask

  // Present a resolve, check penalty and the recovery sequence that follows
  task automatic resolve(input string req, input logic [31:0] pc, input logic h,
                         input logic [31:0] ptgt, input logic tk, input logic [31:0] tgt,
                         input logic u, input logic [31:0] ti, input logic [1:0] e_pen);
    @(negedge clk);
    fv = 1'b0;
    rv = 1'b1; rpc = pc; rhit = h; rptgt = ptgt; rtaken = tk; rtgt = tgt;
    runc = u; rtinstr = ti;
    #1;
    chk({req, " pen_valid R12"}, {31'd0, pen_v}, 32'd1);
    chk({req, " pen"}, {30'd0, pen}, {30'd0, e_pen});
    @(negedge clk);
    rv = 1'b0;
    #1;
    if (e_pen == 2'd2) begin
      chk({req, " R8 stall c1"}, {31'd0, stall}, 32'd1);
      chk({req, " R8 no redirect c1"}, {31'd0, redir}, 32'd0);
      @(negedge clk); #1;
      chk({req, " R8 stall c2"}, {31'd0, stall}, 32'd1);
      chk({req, " R8 redirect"}, {31'd0, redir}, 32'd1);
      chk({req, " R8 redirect pc"}, redir_pc, tk ? tgt : pc + 32'd4);
      @(negedge clk); #1;
      chk({req, " R8 stall end"}, {31'd0, stall}, 32'd0);
    end else begin
      chk({req, " no stall"}, {31'd0, stall}, 32'd0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk); fv = 1'b1; fpc = 32'h0000_1000; imem = 32'h1234_5678; #1;
    chk("R1 hit", {31'd0, hit}, 32'd0);
    chk("R1 stall", {31'd0, stall}, 32'd0);
    chk("R1 fold", {31'd0, fold}, 32'd0);
    chk("R1 npc", npc, 32'h0000_1004);
    chk("R1 instr", instr, 32'h1234_5678);
  endtask

  task automatic t_miss_not_taken();
    resolve("R3", 32'h0000_2008, 1'b0, 32'h0, 1'b0, 32'h0000_3000, 1'b0, 32'h0, 2'd0);
    look(32'h0000_2008, "R3 no alloc", 1'b0, 32'h0000_200C);
  endtask

  task automatic t_miss_taken_and_hit();
    resolve("R4", 32'h0000_1010, 1'b0, 32'h0, 1'b1, 32'h0000_4000, 1'b0, 32'h0, 2'd0 + 2'd2);
    look(32'h0000_1010, "R4 R2 alloc hit", 1'b1, 32'h0000_4000);
    #0 chk("R9 cond passes imem", instr, 32'hABCD0000 ^ 32'h0000_1010);
    look(32'h0000_5010, "R2 alias miss", 1'b0, 32'h0000_5014);
    @(negedge clk); fv = 1'b0; fpc = 32'h0000_1010; #1;
    chk("R2 fetch_valid low", {31'd0, hit}, 32'd0);
  endtask

  task automatic t_hit_correct();
    resolve("R5", 32'h0000_1010, 1'b1, 32'h0000_4000, 1'b1, 32'h0000_4000, 1'b0, 32'h0, 2'd0);
    look(32'h0000_1010, "R5 unchanged", 1'b1, 32'h0000_4000);
  endtask

  task automatic t_hit_wrong_target();
    resolve("R6", 32'h0000_1010, 1'b1, 32'h0000_4000, 1'b1, 32'h0000_4800, 1'b0, 32'h0, 2'd2);
    look(32'h0000_1010, "R6 new target", 1'b1, 32'h0000_4800);
  endtask

  task automatic t_hit_not_taken();
    resolve("R7", 32'h0000_1010, 1'b1, 32'h0000_4800, 1'b0, 32'h0000_4800, 1'b0, 32'h0, 2'd2);
    look(32'h0000_1010, "R7 invalidated", 1'b0, 32'h0000_1014);
  endtask

  task automatic t_fold();
    resolve("R9 alloc", 32'h0000_2020, 1'b0, 32'h0, 1'b1, 32'h0000_6000, 1'b1, 32'hDEAD_BEEF, 2'd2);
    look(32'h0000_2020, "R9 fold npc", 1'b1, 32'h0000_6004);
    chk("R9 fold flag", {31'd0, fold}, 32'd1);
    chk("R9 fold instr", instr, 32'hDEAD_BEEF);
  endtask

  task automatic t_collision_and_ignore();
    // Entry A at index 3, then B at index 3 with a different tag
    resolve("R10 setup", 32'h0000_100C, 1'b0, 32'h0, 1'b1, 32'h0000_7000, 1'b0, 32'h0, 2'd2);
    @(negedge clk);
    rv = 1'b1; rpc = 32'h0000_204C; rhit = 1'b0; rtaken = 1'b1; rtgt = 32'h0000_8000;
    runc = 1'b0; rtinstr = 32'h0; fv = 1'b0;
    #1;
    chk("R10 setup pen", {30'd0, pen}, 32'd2);
    // Update cycle: lookup of A at the index being written
    @(negedge clk);
    fv = 1'b1; fpc = 32'h0000_100C; imem = 32'h0;
    // Resolve during stall must be ignored
    rv = 1'b1; rpc = 32'h0000_3030; rhit = 1'b0; rtaken = 1'b1; rtgt = 32'h0000_9000;
    #1;
    chk("R10 miss on write index", {31'd0, hit}, 32'd0);
    chk("R11 no pen report", {31'd0, pen_v}, 32'd0);
    @(negedge clk); #1;
    chk("R11 no pen report c2", {31'd0, pen_v}, 32'd0);
    chk("R8 redirect B", redir_pc, 32'h0000_8000);
    @(negedge clk); rv = 1'b0; #1;
    chk("R11 no extra stall", {31'd0, stall}, 32'd0);
    look(32'h0000_100C, "R10 A replaced", 1'b0, 32'h0000_1010);
    look(32'h0000_204C, "R10 B present", 1'b1, 32'h0000_8000);
    look(32'h0000_3030, "R11 not allocated", 1'b0, 32'h0000_3034);
  endtask

  initial begin
    rst_n = 1'b0; fv = 1'b0; fpc = '0; imem = '0; rv = 1'b0; rpc = '0; rhit = 1'b0;
    rptgt = '0; rtaken = 1'b0; rtgt = '0; runc = 1'b0; rtinstr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_miss_not_taken();
    t_miss_taken_and_hit();
    t_hit_correct();
    t_hit_wrong_target();
    t_hit_not_taken();
    t_fold();
    t_collision_and_ignore();
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule